// File: doc/BRIEF.md
# MDIO Management Register Responder

This block sits on the PHY end of a two-wire serial management bus. It watches the management clock and data lines, recognises clause-22 style frames sent to its own device address, and answers them from a bank of 32 sixteen-bit registers. Writes store a word in the addressed register. Reads send a word back to the station on the shared data line, which the responder drives only for the short window the frame allots to it.

Some register slots hold no storage of their own. Their values are built at read time from a link-up input and from the ability-advertisement register. These are the status word, the partner-ability word, a fixed vendor word and a speed/duplex summary. This lets a station walk its usual bring-up sequence against a PHY that does no real negotiation.

The management clock and data inputs are assumed to be already synchronous to `clk`. The block finds MDC edges by comparing the line with its value on the previous clock cycle.

Top module: `mdio_phy_responder`

## Requirements
- R1: After reset the data line is not driven (`mdioOe` = 0), and reads return register 0 = 0x3100, register 2 = 0x0141, register 3 = 0x0CC2 and register 4 = 0x01E1.
- R2: A frame is any run of ones, then the start bits 0,1, then a 2-bit opcode (1,0 = read; 0,1 = write), the 5-bit device address MSB first, the 5-bit register index MSB first, 2 turnaround bits and 16 data bits MSB first. Every incoming bit is sampled on an MDC rising edge.
- R3: On a read that matches, the responder drives 0 during the second turnaround bit and then the 16 data bits MSB first. Each value is updated just after an MDC falling edge. The line is released on the falling edge that follows the last data bit.
- R4: A frame is ignored if its device address differs from `PHY_ADDR` (default 7) or its opcode is 0,0 or 1,1. Such a frame never drives the line and never changes a register.
- R5: Register 1 reads 0x782E while `linkUp` is 1 and 0x0000 while it is 0.
- R6: Register 5 reads 0x4000 OR (register 4 AND 0x01E0) OR 0x0001.
- R7: Register 17 always reads 0x4C00.
- R8: With the link up, register 18 has bit 10 = reg4[7] OR reg4[8] and bit 11 = reg4[8] OR reg4[6], with every other bit 0. With the link down it reads 0.
- R9: A matching write stores its 16 data bits in the addressed register. Every register other than 1, 5, 17 and 18 reads back its stored value.
- R10: Every matching write clears bit 15 of register 0, even when register 0 was the one written.
- R11: A start pattern that is not 0,1 counts as preamble. After one or more zeros, the next 1 completes a valid start and the frame is decoded from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; MDC and MDIO are sampled on it |
| rstN | input | 1 | Active-low synchronous reset |
| mdc | input | 1 | Management clock from the station |
| mdioIn | input | 1 | Resolved value of the management data line |
| linkUp | input | 1 | 1 while the media link is up |
| mdioOut | output | 1 | Value the responder places on the data line |
| mdioOe | output | 1 | Output enable for `mdioOut` |

## Verification
Each incoming bit is taken on the first `clk` edge that sees MDC high. Each outgoing bit is updated on the first `clk` edge that sees MDC low, so a response value is due one system clock after the falling edge of MDC. The bench changes MDC and the station's data only on the falling edge of `clk`. It holds each MDC phase for four clocks and samples the line just before it raises MDC, so every sample falls three clocks after the responder's update is due. The release of the line is checked four clocks after the falling MDC edge that follows the last data bit.

// File: rtl/mdio_phy_pkg.sv
package mdio_phy_pkg;

  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int NUM_REGS   = 1 << ADDR_W;
  localparam int OP_W       = 2;
  localparam int TA_W       = 2;
  localparam int HDR_BITS   = OP_W + 2 * ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + TA_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  localparam logic [OP_W-1:0] OP_READ  = 2'b10;
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

  // Slots whose read value is computed
  localparam logic [ADDR_W-1:0] SLOT_STATUS  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] SLOT_ADVERT  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] SLOT_PARTNER = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] SLOT_FIXED   = ADDR_W'(17);
  localparam logic [ADDR_W-1:0] SLOT_SPEED   = ADDR_W'(18);

  localparam logic [DATA_W-1:0] STATUS_UP    = 16'h782E;
  localparam logic [DATA_W-1:0] PARTNER_BASE = 16'h4001;
  localparam logic [DATA_W-1:0] ABILITY_MASK = 16'h01E0;
  localparam logic [DATA_W-1:0] FIXED_WORD   = 16'h4C00;

  localparam int ADV_10FULL  = 6;
  localparam int ADV_100HALF = 7;
  localparam int ADV_100FULL = 8;
  localparam int SPEED_BIT   = 10;
  localparam int DUPLEX_BIT  = 11;
  localparam int SOFT_RST_BIT = DATA_W - 1;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_SOF,
    ST_BITS,
    ST_TAIL
  } frameStateT;

  typedef struct packed {
    logic              commitWrite;
    logic [ADDR_W-1:0] regAddr;
    logic [DATA_W-1:0] wrData;
  } regCmdT;

  function automatic logic [DATA_W-1:0] resetWord(input int idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0141;
      3:       return 16'h0CC2;
      4:       return 16'h01E1;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_phy_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PHY_ADDR = ADDR_W'(7)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mdc,
  input  logic              mdioIn,
  input  logic [DATA_W-1:0] rdData,
  output regCmdT            cmd,
  output logic              mdioOut,
  output logic              mdioOe
);

  localparam logic [CNT_W-1:0] CNT_HDR_LAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_LAST     = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_LOAD     = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] CNT_TA2      = CNT_W'(HDR_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_DATA0    = CNT_W'(HDR_BITS + TA_W);

  logic              mdcQ;
  logic              mdcRise, mdcFall;
  frameStateT        stateQ;
  logic [CNT_W-1:0]  cntQ;
  logic [DATA_W-1:0] shiftInQ;
  logic [DATA_W-1:0] shiftOutQ;
  logic              rdHitQ, wrHitQ;
  logic [ADDR_W-1:0] regAddrQ;

  logic [HDR_BITS-1:0] header;
  logic [OP_W-1:0]     hdrOp;
  logic                hdrAddrHit;
  logic                hdrDone, lastBit;

  assign mdcRise = mdc & ~mdcQ;
  assign mdcFall = ~mdc & mdcQ;

  assign header     = {shiftInQ[HDR_BITS-2:0], mdioIn};
  assign hdrOp      = header[HDR_BITS-1 -: OP_W];
  assign hdrAddrHit = (header[2*ADDR_W-1:ADDR_W] == PHY_ADDR);
  assign hdrDone    = mdcRise && (stateQ == ST_BITS) && (cntQ == CNT_HDR_LAST);
  assign lastBit    = mdcRise && (stateQ == ST_BITS) && (cntQ == CNT_LAST);

  assign cmd.commitWrite = lastBit && wrHitQ;
  assign cmd.regAddr     = regAddrQ;
  assign cmd.wrData      = {shiftInQ[DATA_W-2:0], mdioIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mdcQ      <= 1'b0;
      stateQ    <= ST_HUNT;
      cntQ      <= '0;
      shiftInQ  <= '0;
      shiftOutQ <= '0;
      rdHitQ    <= 1'b0;
      wrHitQ    <= 1'b0;
      regAddrQ  <= '0;
      mdioOut   <= 1'b0;
      mdioOe    <= 1'b0;
    end else begin
      mdcQ <= mdc;
      if (mdcRise) begin
        unique case (stateQ)
          ST_HUNT: if (!mdioIn) stateQ <= ST_SOF;
          ST_SOF: begin
            if (mdioIn) begin
              stateQ <= ST_BITS;
              cntQ   <= '0;
              rdHitQ <= 1'b0;
              wrHitQ <= 1'b0;
            end
          end
          ST_BITS: begin
            shiftInQ <= {shiftInQ[DATA_W-2:0], mdioIn};
            cntQ     <= cntQ + CNT_W'(1);
            if (hdrDone) begin
              rdHitQ   <= hdrAddrHit && (hdrOp == OP_READ);
              wrHitQ   <= hdrAddrHit && (hdrOp == OP_WRITE);
              regAddrQ <= header[ADDR_W-1:0];
            end
            if (lastBit) stateQ <= ST_TAIL;
          end
          default: ;
        endcase
      end else if (mdcFall) begin
        if (stateQ == ST_BITS && rdHitQ) begin
          if (cntQ == CNT_LOAD) begin
            shiftOutQ <= rdData;
          end else if (cntQ == CNT_TA2) begin
            mdioOe  <= 1'b1;
            mdioOut <= 1'b0;
          end else if (cntQ >= CNT_DATA0) begin
            mdioOut   <= shiftOutQ[DATA_W-1];
            shiftOutQ <= {shiftOutQ[DATA_W-2:0], 1'b0};
          end
        end else if (stateQ == ST_TAIL) begin
          mdioOe  <= 1'b0;
          mdioOut <= 1'b0;
          stateQ  <= ST_HUNT;
        end
      end
    end
  end

  // R3
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(mdioOe) || !$stable(mdioOut)) |-> !mdcQ);

  // R3
  ta_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdioOe) |-> !mdioOut);

  // R4
  no_foreign_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> rdHitQ);

  // R4
  no_foreign_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commitWrite |-> (wrHitQ && !rdHitQ));

endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
  import mdio_phy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  regCmdT            cmd,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic [DATA_W-1:0] advert;

  assign advert = regQ[SLOT_ADVERT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= resetWord(i);
    end else if (cmd.commitWrite) begin
      regQ[cmd.regAddr]     <= cmd.wrData;
      regQ[0][SOFT_RST_BIT] <= 1'b0;
    end
  end

  always_comb begin
    rdData = regQ[cmd.regAddr];
    case (cmd.regAddr)
      SLOT_STATUS:  rdData = linkUp ? STATUS_UP : '0;
      SLOT_PARTNER: rdData = PARTNER_BASE | (advert & ABILITY_MASK);
      SLOT_FIXED:   rdData = FIXED_WORD;
      SLOT_SPEED: begin
        rdData = '0;
        if (linkUp) begin
          rdData[SPEED_BIT]  = advert[ADV_100HALF] | advert[ADV_100FULL];
          rdData[DUPLEX_BIT] = advert[ADV_100FULL] | advert[ADV_10FULL];
        end
      end
      default: ;
    endcase
  end

  // R10
  soft_reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commitWrite |=> !regQ[0][SOFT_RST_BIT]);

  // R9
  stored_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.commitWrite && cmd.regAddr != '0) |=> regQ[$past(cmd.regAddr)] == $past(cmd.wrData));

endmodule

// File: rtl/mdio_phy_responder.sv
module mdio_phy_responder
  import mdio_phy_pkg::*;
#(
  parameter int PHY_ADDR = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic mdc,
  input  logic mdioIn,
  input  logic linkUp,
  output logic mdioOut,
  output logic mdioOe
);

  regCmdT            regCmd;
  logic [DATA_W-1:0] rdData;

  mdio_frame_ctrl #(
    .PHY_ADDR(ADDR_W'(PHY_ADDR))
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .mdc    (mdc),
    .mdioIn (mdioIn),
    .rdData (rdData),
    .cmd    (regCmd),
    .mdioOut(mdioOut),
    .mdioOe (mdioOe)
  );

  phy_reg_bank i_bank (
    .clk   (clk),
    .rstN  (rstN),
    .linkUp(linkUp),
    .cmd   (regCmd),
    .rdData(rdData)
  );

endmodule

// File: tb/test_mdio_phy_responder.sv
module test_mdio_phy_responder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mdc = 1'b0;
  logic masterBit = 1'b1;
  logic linkUp = 1'b1;
  logic dutOut, dutOe;
  logic mdioLine;

  int checks = 0;
  int fails = 0;
  bit oeSeen = 1'b0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic [15:0] val;
    logic        ta;
    logic        drive;
  } itemT;

  itemT expQ[$];
  itemT obsQ[$];

  always #5 clk = ~clk;

  assign mdioLine = dutOe ? dutOut : masterBit;

  mdio_phy_responder i_mdio_phy_responder (
    .clk    (clk),
    .rstN   (rstN),
    .mdc    (mdc),
    .mdioIn (mdioLine),
    .linkUp (linkUp),
    .mdioOut(dutOut),
    .mdioOe (dutOe)
  );

  always @(negedge clk) if (dutOe) oeSeen = 1'b1;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clockBit(input logic b, output logic s);
    @(negedge clk);
    mdc = 1'b0;
    masterBit = b;
    repeat (4) @(negedge clk);
    s = mdioLine;
    mdc = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    logic s;
    clockBit(b, s);
  endtask

  task automatic header(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] regIdx,
                        input bit junkStart);
    for (int i = 0; i < 32; i++) sendBit(1'b1);
    if (junkStart) begin
      sendBit(1'b0);
      sendBit(1'b0);
    end
    sendBit(1'b0);
    sendBit(1'b1);
    for (int i = 1; i >= 0; i--) sendBit(op[i]);
    for (int i = 4; i >= 0; i--) sendBit(phy[i]);
    for (int i = 4; i >= 0; i--) sendBit(regIdx[i]);
  endtask

  task automatic writeReg(input logic [4:0] phy, input logic [4:0] regIdx, input logic [15:0] data,
                          input logic [1:0] op);
    header(op, phy, regIdx, 1'b0);
    sendBit(1'b1);
    sendBit(1'b0);
    for (int i = 15; i >= 0; i--) sendBit(data[i]);
    @(negedge clk);
    mdc = 1'b0;
    masterBit = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic readReg(input string tag, input logic [4:0] phy, input logic [4:0] regIdx,
                         input logic [15:0] expVal, input bit expDrive, input bit junkStart);
    itemT e;
    itemT o;
    logic s;
    e.tag = tag;
    e.val = expDrive ? expVal : 16'hFFFF;
    e.ta = expDrive ? 1'b0 : 1'b1;
    e.drive = expDrive;
    expQ.push_back(e);
    oeSeen = 1'b0;
    header(2'b10, phy, regIdx, junkStart);
    o.tag = tag;
    clockBit(1'b1, s);
    clockBit(1'b1, s);
    o.ta = s;
    for (int i = 15; i >= 0; i--) begin
      clockBit(1'b1, s);
      o.val[i] = s;
    end
    @(negedge clk);
    mdc = 1'b0;
    repeat (4) @(negedge clk);
    o.drive = oeSeen;
    obsQ.push_back(o);
    if (expDrive) check({tag, " R3 release"}, {15'b0, dutOe}, 16'h0000);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      itemT e;
      itemT o;
      wait (obsQ.size() != 0);
      e = expQ.pop_front();
      o = obsQ.pop_front();
      checks++;
      if (o.val !== e.val || o.ta !== e.ta || o.drive !== e.drive) begin
        fails++;
        $display("FAIL %s actual=%h ta=%b drive=%b expected=%h ta=%b drive=%b",
                 e.tag, o.val, o.ta, o.drive, e.val, e.ta, e.drive);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle line", {15'b0, dutOe}, 16'h0000);

    readReg("R1 reg0", 5'd7, 5'd0, 16'h3100, 1, 0);
    readReg("R1 reg2", 5'd7, 5'd2, 16'h0141, 1, 0);
    readReg("R1 reg3", 5'd7, 5'd3, 16'h0CC2, 1, 0);
    readReg("R1 reg4", 5'd7, 5'd4, 16'h01E1, 1, 0);

    readReg("R5 link up", 5'd7, 5'd1, 16'h782E, 1, 0);
    readReg("R6 default", 5'd7, 5'd5, 16'h41E1, 1, 0);
    readReg("R7 fixed", 5'd7, 5'd17, 16'h4C00, 1, 0);
    readReg("R8 default", 5'd7, 5'd18, 16'h0C00, 1, 0);

    linkUp = 1'b0;
    readReg("R5 link down", 5'd7, 5'd1, 16'h0000, 1, 0);
    readReg("R8 link down", 5'd7, 5'd18, 16'h0000, 1, 0);
    readReg("R7 link down", 5'd7, 5'd17, 16'h4C00, 1, 0);
    linkUp = 1'b1;

    writeReg(5'd7, 5'd4, 16'h0061, 2'b01);
    readReg("R6 10M only", 5'd7, 5'd5, 16'h4061, 1, 0);
    readReg("R8 10M only", 5'd7, 5'd18, 16'h0800, 1, 0);
    writeReg(5'd7, 5'd4, 16'h0081, 2'b01);
    readReg("R6 100 half", 5'd7, 5'd5, 16'h4081, 1, 0);
    readReg("R8 100 half", 5'd7, 5'd18, 16'h0400, 1, 0);

    writeReg(5'd7, 5'd9, 16'hA5C3, 2'b01);
    readReg("R9 reg9", 5'd7, 5'd9, 16'hA5C3, 1, 0);
    writeReg(5'd7, 5'd31, 16'h1234, 2'b01);
    readReg("R9 reg31", 5'd7, 5'd31, 16'h1234, 1, 0);

    writeReg(5'd7, 5'd0, 16'h9140, 2'b01);
    readReg("R10 reg0", 5'd7, 5'd0, 16'h1140, 1, 0);

    writeReg(5'd3, 5'd9, 16'hFFFF, 2'b01);
    readReg("R4 foreign write", 5'd7, 5'd9, 16'hA5C3, 1, 0);
    readReg("R4 foreign read", 5'd3, 5'd9, 16'h0000, 0, 0);
    writeReg(5'd7, 5'd9, 16'h0000, 2'b11);
    readReg("R4 bad opcode", 5'd7, 5'd9, 16'hA5C3, 1, 0);

    readReg("R11 resync", 5'd7, 5'd2, 16'h0141, 1, 1);

    wait (obsQ.size() == 0);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule